// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block holds the three-entry program-counter window of a 32-bit core with one architectural delay slot: the address of the instruction now completing (`o_pc`), the next one (`o_npc`, the delay slot when a transfer resolves) and the one after (`o_nnpc`). Each cycle in which the pipeline presents a resolved instruction (`i_adv` high), the block reads a decoded transfer kind, the immediate fields, two condition flags and a register-supplied target. It then moves the window forward by one of three steps.

A decode process maps the transfer kind and its condition to one of four named steps:

- STEP_HOLD: no advance.
- STEP_SEQ: sequential. The window shifts by one instruction.
- STEP_TAKE: taken transfer. The delay slot becomes `o_pc`, and the target enters behind it.
- STEP_SKIP: annulled slot. The window shifts by two instructions, so the delay slot is never executed.

A separate register process applies the chosen step to the window. Link variants report a write of the return address to a link register. In the same cycle, a squash pulse tells the pipeline to drop the delay-slot instruction of a likely branch that was not taken.

Top module: `slot_pc_unit`

## Requirements
- R1: After reset, `o_pc` equals RESET_VEC (default 0xBFC00000), `o_npc` equals RESET_VEC+4 and `o_nnpc` equals RESET_VEC+8.
- R2: While `i_adv` is low, the window holds its value and `o_annul` and `o_link_we` stay low, whatever the other inputs are.
- R3: `i_kind` values 0, 6 and 7 are sequential. A branch that is not taken is also sequential, except for a likely branch. A sequential step sets pc←npc, npc←nnpc, nnpc←nnpc+4.
- R4: A taken PC-relative branch (kind 1, or kind 2 with `i_cond` high) forms its target as pc+4+D. D is `i_offset` shifted left by 2 and sign-extended from bit 17. The step sets pc←npc, npc←target, nnpc←target+4.
- R5: A likely branch (kind 2) with `i_cond` low takes the skip step: pc←nnpc, npc←nnpc+4, nnpc←nnpc+8.
- R6: A region jump (kind 3) is always taken. Its target is pc[31:28] concatenated with `i_jtarg` and two zero bits.
- R7: A register-indirect jump (kind 4) is always taken, with target `i_reg_tgt`, and ignores both condition flags.
- R8: The alternate branch (kind 5) is PC-relative like kind 1. Its condition is `i_alt_cond`, and `i_cond` has no effect on it.
- R9: With `i_adv` and `i_link` high and kind 1 to 5, `o_link_we` is high and `o_link_val` equals the current nnpc. This holds whether or not the branch is taken. `o_link_idx` is 31 for kinds 1 to 4 and ALT_LINK_IDX (default 32) for kind 5. For kinds 0, 6 and 7, `i_link` is ignored.
- R10: `o_annul` is high only in the advancing cycle of a not-taken likely branch. A taken likely branch executes its delay slot with `o_annul` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_adv | input | 1 | Resolved instruction present; step the window |
| i_kind | input | 3 | Transfer kind (0 none, 1 branch, 2 likely branch, 3 region jump, 4 indirect jump, 5 alternate branch) |
| i_link | input | 1 | Link variant |
| i_offset | input | 16 | Branch offset in instructions |
| i_jtarg | input | 26 | Region jump target field |
| i_cond | input | 1 | Condition for kinds 1 and 2 |
| i_alt_cond | input | 1 | Condition for kind 5 |
| i_reg_tgt | input | 32 | Register-indirect target |
| o_pc | output | 32 | Address of the completing instruction |
| o_npc | output | 32 | Next address (delay slot) |
| o_nnpc | output | 32 | Address after the next |
| o_annul | output | 1 | Squash the delay-slot instruction this cycle |
| o_link_we | output | 1 | Link register write enable |
| o_link_idx | output | 6 | Link register index |
| o_link_val | output | 32 | Return address to write |

## Verification
Two functions can fall in the same cycle: a link write and a window step. This covers a taken step, a sequential step and the annul skip, and a not-taken likely branch with link raises the squash pulse and the link write together. The return value must be the nnpc from before the step, not the one after it. The bench provokes these overlaps with directed link-likely and link-alternate branches, then with random kinds that have the link flag set about half the time. It judges each cycle twice: the combinational annul and link outputs just after the inputs change, and the whole window after the clock edge, both against a bench model built from the requirements.

// File: rtl/slot_pc_pkg.sv
package slot_pc_pkg;

    typedef enum logic [2:0] {
        XK_NONE   = 3'd0,
        XK_BR     = 3'd1,
        XK_BRL    = 3'd2,
        XK_REGION = 3'd3,
        XK_INDIR  = 3'd4,
        XK_ALTBR  = 3'd5,
        XK_RSV6   = 3'd6,
        XK_RSV7   = 3'd7
    } xfer_kind_e;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_SEQ  = 2'd1,
        STEP_TAKE = 2'd2,
        STEP_SKIP = 2'd3
    } step_e;

endpackage

// File: rtl/slot_pc_target.sv
module slot_pc_target
    import slot_pc_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int OFS_W    = 16,
    parameter int JT_W     = 26,
    parameter int IB       = 4
) (
    input  logic [XLEN-1:0]  pc,
    input  xfer_kind_e       kind,
    input  logic [OFS_W-1:0] offset,
    input  logic [JT_W-1:0]  jtarg,
    input  logic [XLEN-1:0]  reg_tgt,
    output logic [XLEN-1:0]  tgt
);
    localparam int SH       = $clog2(IB);
    localparam int DISP_W   = OFS_W + SH;
    localparam int REGION_W = XLEN - JT_W - SH;

    logic [XLEN-1:0] disp;
    logic [XLEN-1:0] rel_tgt;
    logic [XLEN-1:0] region_tgt;

    assign disp       = {{(XLEN-DISP_W){offset[OFS_W-1]}}, offset, {SH{1'b0}}};
    assign rel_tgt    = pc + XLEN'(IB) + disp;

    generate
        if (REGION_W > 0) begin : g_region
            assign region_tgt = {pc[XLEN-1 -: REGION_W], jtarg, {SH{1'b0}}};
        end else begin : g_flat
            assign region_tgt = XLEN'({jtarg, {SH{1'b0}}});
        end
    endgenerate

    always_comb begin
        unique case (kind)
            XK_REGION: tgt = region_tgt;
            XK_INDIR:  tgt = reg_tgt;
            default:   tgt = rel_tgt;
        endcase
    end
endmodule

// File: rtl/slot_pc_resolve.sv
module slot_pc_resolve
    import slot_pc_pkg::*;
#(
    parameter int RIDX_W       = 6,
    parameter int MAIN_LINK_IDX = 31,
    parameter int ALT_LINK_IDX  = 32
) (
    input  logic              adv,
    input  xfer_kind_e        kind,
    input  logic              link,
    input  logic              cond,
    input  logic              alt_cond,
    output step_e             step,
    output logic              annul,
    output logic              link_we,
    output logic [RIDX_W-1:0] link_idx
);
    logic is_xfer;

    always_comb begin
        step     = STEP_HOLD;
        is_xfer  = 1'b0;
        link_idx = RIDX_W'(MAIN_LINK_IDX);
        if (adv) begin
            unique case (kind)
                XK_BR: begin
                    is_xfer = 1'b1;
                    step    = cond ? STEP_TAKE : STEP_SEQ;
                end
                XK_BRL: begin
                    is_xfer = 1'b1;
                    step    = cond ? STEP_TAKE : STEP_SKIP;
                end
                XK_REGION, XK_INDIR: begin
                    is_xfer = 1'b1;
                    step    = STEP_TAKE;
                end
                XK_ALTBR: begin
                    is_xfer  = 1'b1;
                    step     = alt_cond ? STEP_TAKE : STEP_SEQ;
                    link_idx = RIDX_W'(ALT_LINK_IDX);
                end
                XK_NONE, XK_RSV6, XK_RSV7: begin
                    step = STEP_SEQ;
                end
            endcase
        end
    end

    assign annul   = (step == STEP_SKIP);
    assign link_we = is_xfer && link;
endmodule

// File: rtl/slot_pc_state.sv
module slot_pc_state
    import slot_pc_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              IB        = 4,
    parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  step_e           step,
    input  logic [XLEN-1:0] tgt,
    output logic [XLEN-1:0] pc,
    output logic [XLEN-1:0] npc,
    output logic [XLEN-1:0] nnpc
);
    localparam logic [XLEN-1:0] STRIDE = XLEN'(IB);

    logic [XLEN-1:0] pc_d, npc_d, nnpc_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc   <= RESET_VEC;
            npc  <= RESET_VEC + STRIDE;
            nnpc <= RESET_VEC + 2 * STRIDE;
        end else begin
            pc   <= pc_d;
            npc  <= npc_d;
            nnpc <= nnpc_d;
        end
    end

    always_comb begin
        unique case (step)
            STEP_HOLD: begin
                pc_d   = pc;
                npc_d  = npc;
                nnpc_d = nnpc;
            end
            STEP_SEQ: begin
                pc_d   = npc;
                npc_d  = nnpc;
                nnpc_d = nnpc + STRIDE;
            end
            STEP_TAKE: begin
                pc_d   = npc;
                npc_d  = tgt;
                nnpc_d = tgt + STRIDE;
            end
            STEP_SKIP: begin
                pc_d   = nnpc;
                npc_d  = nnpc + STRIDE;
                nnpc_d = nnpc + 2 * STRIDE;
            end
        endcase
    end
endmodule

// File: rtl/slot_pc_unit.sv
module slot_pc_unit
    import slot_pc_pkg::*;
#(
    parameter int              XLEN          = 32,
    parameter int              OFS_W         = 16,
    parameter int              JT_W          = 26,
    parameter int              IB            = 4,
    parameter int              RIDX_W        = 6,
    parameter int              MAIN_LINK_IDX = 31,
    parameter int              ALT_LINK_IDX  = 32,
    parameter logic [XLEN-1:0] RESET_VEC     = 32'hBFC0_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_adv,
    input  logic [2:0]        i_kind,
    input  logic              i_link,
    input  logic [OFS_W-1:0]  i_offset,
    input  logic [JT_W-1:0]   i_jtarg,
    input  logic              i_cond,
    input  logic              i_alt_cond,
    input  logic [XLEN-1:0]   i_reg_tgt,
    output logic [XLEN-1:0]   o_pc,
    output logic [XLEN-1:0]   o_npc,
    output logic [XLEN-1:0]   o_nnpc,
    output logic              o_annul,
    output logic              o_link_we,
    output logic [RIDX_W-1:0] o_link_idx,
    output logic [XLEN-1:0]   o_link_val
);
    xfer_kind_e      kind;
    step_e           step;
    logic [XLEN-1:0] tgt;

    assign kind = xfer_kind_e'(i_kind);

    slot_pc_target #(
        .XLEN(XLEN), .OFS_W(OFS_W), .JT_W(JT_W), .IB(IB)
    ) u_target (
        .pc(o_pc), .kind(kind), .offset(i_offset), .jtarg(i_jtarg),
        .reg_tgt(i_reg_tgt), .tgt(tgt)
    );

    slot_pc_resolve #(
        .RIDX_W(RIDX_W), .MAIN_LINK_IDX(MAIN_LINK_IDX), .ALT_LINK_IDX(ALT_LINK_IDX)
    ) u_resolve (
        .adv(i_adv), .kind(kind), .link(i_link), .cond(i_cond),
        .alt_cond(i_alt_cond), .step(step), .annul(o_annul),
        .link_we(o_link_we), .link_idx(o_link_idx)
    );

    slot_pc_state #(
        .XLEN(XLEN), .IB(IB), .RESET_VEC(RESET_VEC)
    ) u_state (
        .clk(clk), .rst_n(rst_n), .step(step), .tgt(tgt),
        .pc(o_pc), .npc(o_npc), .nnpc(o_nnpc)
    );

    assign o_link_val = o_nnpc;
endmodule

// File: rtl/slot_pc_unit_chk.sv
module slot_pc_unit_chk #(
    parameter int XLEN   = 32,
    parameter int IB     = 4,
    parameter int RIDX_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              i_adv,
    input logic [2:0]        i_kind,
    input logic              i_link,
    input logic              i_cond,
    input logic [XLEN-1:0]   i_reg_tgt,
    input logic [XLEN-1:0]   o_pc,
    input logic [XLEN-1:0]   o_npc,
    input logic [XLEN-1:0]   o_nnpc,
    input logic              o_annul,
    input logic              o_link_we,
    input logic [XLEN-1:0]   o_link_val
);
    // R2: no advance, no movement
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !i_adv |=> ($stable(o_pc) && $stable(o_npc) && $stable(o_nnpc)));

    // R3: every non-skipping advance moves the slot into pc
    p_adv_slot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (i_adv && !o_annul) |=> (o_pc == $past(o_npc)));

    // R4: nnpc always trails npc by one instruction after an advance
    p_nnpc_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        i_adv |=> (o_nnpc == o_npc + XLEN'(IB)));

    // R5: an annulled slot is jumped over
    p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        o_annul |=> (o_pc == $past(o_nnpc)));

    // R7: indirect jump lands on the register target
    p_indirect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (i_adv && i_kind == 3'd4) |=> (o_npc == $past(i_reg_tgt)));

    // R9: link write only on an advancing link variant, carrying nnpc
    p_link_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        o_link_we |-> (i_adv && i_link && o_link_val == o_nnpc));

    // R10: squash pulse only for a not-taken likely branch
    p_annul_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        o_annul |-> (i_adv && i_kind == 3'd2 && !i_cond));
endmodule

bind slot_pc_unit slot_pc_unit_chk #(
    .XLEN(XLEN), .IB(IB), .RIDX_W(RIDX_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .i_adv(i_adv), .i_kind(i_kind), .i_link(i_link),
    .i_cond(i_cond), .i_reg_tgt(i_reg_tgt), .o_pc(o_pc), .o_npc(o_npc),
    .o_nnpc(o_nnpc), .o_annul(o_annul), .o_link_we(o_link_we),
    .o_link_val(o_link_val)
);

// File: tb/slot_pc_unit_tb.sv
module slot_pc_unit_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] VEC = 32'hBFC0_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_adv = 1'b0;
    logic [2:0]  i_kind = 3'd0;
    logic        i_link = 1'b0;
    logic [15:0] i_offset = 16'd0;
    logic [25:0] i_jtarg = 26'd0;
    logic        i_cond = 1'b0;
    logic        i_alt_cond = 1'b0;
    logic [31:0] i_reg_tgt = 32'd0;
    logic [31:0] o_pc, o_npc, o_nnpc, o_link_val;
    logic        o_annul, o_link_we;
    logic [5:0]  o_link_idx;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_pc, m_npc, m_nnpc;

    always #(CLK_PERIOD/2) clk = ~clk;

    slot_pc_unit dut_i (
        .clk(clk), .rst_n(rst_n), .i_adv(i_adv), .i_kind(i_kind), .i_link(i_link),
        .i_offset(i_offset), .i_jtarg(i_jtarg), .i_cond(i_cond),
        .i_alt_cond(i_alt_cond), .i_reg_tgt(i_reg_tgt), .o_pc(o_pc),
        .o_npc(o_npc), .o_nnpc(o_nnpc), .o_annul(o_annul), .o_link_we(o_link_we),
        .o_link_idx(o_link_idx), .o_link_val(o_link_val)
    );

    task automatic cmp(input string req, input logic [95:0] act, input logic [95:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [2:0] k, input logic c);
        case (k)
            3'd1: return c ? "R4" : "R3";
            3'd2: return c ? "R4" : "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R3";
        endcase
    endfunction

    function automatic logic [31:0] rel_target(input logic [31:0] pc, input logic [15:0] ofs);
        return pc + 32'd4 + {{14{ofs[15]}}, ofs, 2'b00};
    endfunction

    // one instruction: drive, check squash/link, clock, check window
    task automatic step(input logic adv, input logic [2:0] k, input logic lk,
                        input logic [15:0] ofs, input logic [25:0] jt,
                        input logic c, input logic ac, input logic [31:0] rt);
        logic        xfer, taken, skip, e_we;
        logic [5:0]  e_idx;
        logic [31:0] tgt;
        string       t;
        @(negedge clk);
        i_adv = adv; i_kind = k; i_link = lk; i_offset = ofs; i_jtarg = jt;
        i_cond = c; i_alt_cond = ac; i_reg_tgt = rt;
        xfer  = (k >= 3'd1 && k <= 3'd5);
        taken = (k == 3'd1 || k == 3'd2) ? c : (k == 3'd5) ? ac : (k == 3'd3 || k == 3'd4);
        skip  = adv && k == 3'd2 && !c;
        e_we  = adv && xfer && lk;
        e_idx = (k == 3'd5) ? 6'd32 : 6'd31;
        tgt   = (k == 3'd3) ? {m_pc[31:28], jt, 2'b00} : (k == 3'd4) ? rt : rel_target(m_pc, ofs);
        t     = adv ? tag_of(k, (k == 3'd5) ? ac : c) : "R2";
        #1;
        cmp(adv ? "R10" : "R2", {95'd0, o_annul}, {95'd0, skip});
        cmp(adv ? "R9" : "R2", {95'd0, o_link_we}, {95'd0, e_we});
        if (e_we) cmp("R9", {58'd0, o_link_idx, o_link_val}, {58'd0, e_idx, m_nnpc});
        if (adv) begin
            if (skip) begin
                m_pc = m_nnpc; m_npc = m_nnpc + 32'd4; m_nnpc = m_nnpc + 32'd8;
            end else if (xfer && taken) begin
                m_pc = m_npc; m_npc = tgt; m_nnpc = tgt + 32'd4;
            end else begin
                m_pc = m_npc; m_npc = m_nnpc; m_nnpc = m_nnpc + 32'd4;
            end
        end
        @(posedge clk);
        #1;
        cmp(t, {o_pc, o_npc, o_nnpc}, {m_pc, m_npc, m_nnpc});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        m_pc = VEC; m_npc = VEC + 32'd4; m_nnpc = VEC + 32'd8;
        cmp("R1", {o_pc, o_npc, o_nnpc}, {m_pc, m_npc, m_nnpc});

        // R2: hold with a tempting taken link branch on the inputs
        step(1'b0, 3'd1, 1'b1, 16'h0010, 26'd0, 1'b1, 1'b1, 32'h0);
        step(1'b0, 3'd2, 1'b1, 16'h0010, 26'd0, 1'b0, 1'b0, 32'h0);
        // R3: plain sequential, reserved kind with link ignored (R9)
        step(1'b1, 3'd0, 1'b0, 16'h0, 26'd0, 1'b0, 1'b0, 32'h0);
        step(1'b1, 3'd6, 1'b1, 16'h0, 26'd0, 1'b1, 1'b1, 32'h0);
        step(1'b1, 3'd7, 1'b1, 16'h0, 26'd0, 1'b1, 1'b1, 32'h0);
        // R4: taken forward, taken negative displacement
        step(1'b1, 3'd1, 1'b0, 16'h0040, 26'd0, 1'b1, 1'b0, 32'h0);
        step(1'b1, 3'd1, 1'b1, 16'hFFFC, 26'd0, 1'b1, 1'b0, 32'h0);
        step(1'b1, 3'd1, 1'b0, 16'h8000, 26'd0, 1'b1, 1'b0, 32'h0);
        // R5/R10: likely not taken with link (squash and link together), likely taken
        step(1'b1, 3'd2, 1'b1, 16'h0100, 26'd0, 1'b0, 1'b1, 32'h0);
        step(1'b1, 3'd2, 1'b1, 16'h0100, 26'd0, 1'b1, 1'b0, 32'h0);
        // R8: alternate flavour ignores i_cond, links to index 32
        step(1'b1, 3'd5, 1'b1, 16'h0020, 26'd0, 1'b1, 1'b0, 32'h0);
        step(1'b1, 3'd5, 1'b1, 16'hFFF0, 26'd0, 1'b0, 1'b1, 32'h0);
        // R7 then R6 across a 256 MB region edge
        step(1'b1, 3'd4, 1'b1, 16'h0, 26'd0, 1'b0, 1'b0, 32'h0FFF_FFF8);
        step(1'b1, 3'd0, 1'b0, 16'h0, 26'd0, 1'b0, 1'b0, 32'h0);
        step(1'b1, 3'd0, 1'b0, 16'h0, 26'd0, 1'b0, 1'b0, 32'h0);
        step(1'b1, 3'd3, 1'b1, 16'h0, 26'h3FF_FFFF, 1'b0, 1'b0, 32'h0);
        step(1'b1, 3'd3, 1'b0, 16'h0, 26'h000_1234, 1'b0, 1'b0, 32'h0);

        for (int n = 0; n < 400; n++) begin
            logic [31:0] r;
            r = $urandom;
            step((r[3:0] != 4'd0), r[6:4], r[7], $urandom, $urandom, r[8], r[9],
                 $urandom & 32'hFFFF_FFFC);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule